// File: doc/BRIEF.md
# Dual-Clause MDIO Management Master

This block is a management-bus master for Ethernet PHYs. Software programs it through four small registers and it generates the MDC clock and the serial MDIO frames. A single shift engine serves both management encodings. In the short (Clause 22) encoding the five-bit device field of the control register names the PHY register, and one frame carries a whole access. In the extended (Clause 45) encoding a register index is first posted in its own address frame, and a separate write or read frame follows it.

A write begins when software stores a 16-bit value in the data register. A read begins when software sets the trigger bit of the control register. When a read finishes, the captured value appears in the data register. If no device pulls the line low in the second turnaround bit, the block raises an error flag and the data register returns all ones. An optional hold stretch delays each MDIO change by a fixed number of system clocks after MDC falls. MDIO is presented as a split tristate: a driven value, an output enable and a sampled input.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all four registers read zero, MDC is low and the MDIO output enable is low. Register selects are 0 status, 1 control, 2 address and 3 data.
- R2: Every frame is 64 bits. The master shifts it out MSB first, in this order: 32 ones, 2-bit start code, 2-bit opcode, 5-bit port field (control bits 9:5), 5-bit device/register field (control bits 4:0), turnaround `10` and 16 data bits. In the short encoding (status bit 0 clear) the start code is `01`, a write uses opcode `01` and a read uses opcode `10`.
- R3: A write to the address register launches an address frame only when the extended encoding is selected (status bit 0 set). That frame has start code `00`, opcode `00`, and the written value as its payload. In the short encoding the write only stores the value, and no MDC activity follows.
- R4: In the extended encoding, a data-register write sends start code `00` with opcode `01`, and a read sends start code `00` with opcode `11`.
- R5: The status busy bit (bit 2) and the data busy bit (bit 31) are both set from the cycle after a transaction is accepted. They stay set for exactly 64 × MDC_DIV cycles.
- R6: During a read, the output enable is low for bits 46 to 63, that is the turnaround and the data. When the read completes, data bits 15:0 hold the 16 bits sampled from MDIO, MSB first.
- R7: If MDIO is high when it is sampled in the second turnaround bit of a read, status bit 3 is set and the data register reads 0xFFFF. Starting any new transaction clears bit 3.
- R8: With status bit 1 clear, MDIO changes on the same clock as the MDC falling edge. With status bit 1 set, it changes HOLD_CLKS clocks later.
- R9: While busy, every register write is ignored. No second frame starts, and the stored configuration, address and data stay as they were.
- R10: MDC runs only during a frame, with a period of MDC_DIV clocks: low for the first half of each bit and high for the second half. MDIO is sampled on the clock on which MDC rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
Busy rises on the clock after the accepting edge and falls exactly 64 × MDC_DIV clocks later. On that same edge the read result and the error flag update, so the bench counts falling clock edges while busy is high and compares the total with 64 × MDC_DIV. A PHY model shifts bits in on MDC rising edges and drives its reply on MDC falling edges. Because the master samples at the MDC rise, the reply is stable for half a bit period before it is taken. All outputs are sampled on falling clock edges. The hold delay is measured as the number of such samples between an MDC fall and the next MDIO change, and that count must be 0, or HOLD_CLKS when the stretch is on.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PAYLOAD_W  = 16;
  localparam int FLD_W      = 5;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_ADDR   = 2'd2,
    SEL_DATA   = 2'd3
  } reg_sel_e;

  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_C22_RD  = 2'b10;
  localparam logic [1:0] OP_C45_RD  = 2'b11;
  localparam logic [1:0] OP_C45_ADR = 2'b00;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic                 ext_enc,
    input logic [1:0]           opcode,
    input logic [FLD_W-1:0]     port_f,
    input logic [FLD_W-1:0]     dev_f,
    input logic [PAYLOAD_W-1:0] payload
  );
    logic [1:0] st;
    st = ext_enc ? 2'b00 : 2'b01;
    return {32'hFFFF_FFFF, st, opcode, port_f, dev_f, 2'b10, payload};
  endfunction

endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
  parameter int MDC_DIV   = 40,
  parameter int HOLD_CLKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold_en,
  output logic launch,
  output logic sample,
  output logic bit_end,
  output logic mdc
);
  localparam int PH_W = $clog2(MDC_DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(MDC_DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(MDC_DIV / 2);
  localparam logic [PH_W-1:0] PH_HOLD = PH_W'(HOLD_CLKS);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            mdc_q, mdc_d;
  logic [PH_W-1:0] launch_pt;

  assign launch_pt = hold_en ? PH_HOLD : '0;

  always_comb begin
    ph_d  = ph_q;
    if (!run)                ph_d = '0;
    else if (ph_q == PH_LAST) ph_d = '0;
    else                     ph_d = ph_q + 1'b1;
    mdc_d = run && (ph_q >= PH_HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      mdc_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      mdc_q <= mdc_d;
    end
  end

  assign launch  = run && (ph_q == launch_pt);
  assign sample  = run && (ph_q == PH_HALF);
  assign bit_end = run && (ph_q == PH_LAST);
  assign mdc     = mdc_q;

  // R10: MDC only rises on the clock that samples MDIO
  a_r10_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $past(sample));

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  is_read_in,
  input  logic                  launch,
  input  logic                  sample,
  input  logic                  bit_end,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  done,
  output logic                  rd_err,
  output logic [PAYLOAD_W-1:0]  rd_value,
  output logic                  mdio_o,
  output logic                  mdio_oe
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] B_LAST = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] B_TA1  = BIT_W'(TA_FIRST);
  localparam logic [BIT_W-1:0] B_TA2  = BIT_W'(TA_FIRST + 1);
  localparam logic [BIT_W-1:0] B_DAT  = BIT_W'(DATA_FIRST);

  logic                  busy_q, busy_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  rd_q, rd_d;
  logic                  do_q, do_d;
  logic                  oe_q, oe_d;
  logic [PAYLOAD_W-1:0]  cap_q, cap_d;
  logic                  err_q, err_d;

  always_comb begin
    busy_d = busy_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    do_d   = do_q;
    oe_d   = oe_q;
    cap_d  = cap_q;
    err_d  = err_q;
    if (start) begin
      busy_d = 1'b1;
      bit_d  = '0;
      sh_d   = frame_in;
      rd_d   = is_read_in;
      cap_d  = '0;
      err_d  = 1'b0;
    end else if (busy_q) begin
      if (launch) begin
        do_d = sh_q[FRAME_BITS-1];
        oe_d = !(rd_q && (bit_q >= B_TA1));
        sh_d = {sh_q[FRAME_BITS-2:0], 1'b1};
      end
      if (sample && rd_q) begin
        if (bit_q == B_TA2) err_d = mdio_i;
        if (bit_q >= B_DAT) cap_d = {cap_q[PAYLOAD_W-2:0], mdio_i};
      end
      if (bit_end) begin
        if (bit_q == B_LAST) begin
          busy_d = 1'b0;
          oe_d   = 1'b0;
          do_d   = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      do_q   <= 1'b1;
      oe_q   <= 1'b0;
      cap_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      do_q   <= do_d;
      oe_q   <= oe_d;
      cap_q  <= cap_d;
      err_q  <= err_d;
    end
  end

  assign busy     = busy_q;
  assign done     = busy_q && bit_end && (bit_q == B_LAST);
  assign rd_err   = err_q;
  assign rd_value = cap_q;
  assign mdio_o   = do_q;
  assign mdio_oe  = oe_q;

  // R2: the register file never launches over a running frame
  a_r2_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R6: line released through turnaround and data of a read
  a_r6_release_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && (bit_q > B_TA1)) |-> !oe_q);

  // R1: master never drives between frames
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !oe_q);

endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            addr,
  input  logic [15:0]           wdata,
  output logic [31:0]           rdata,
  input  logic                  busy,
  input  logic                  done,
  input  logic                  rd_err_in,
  input  logic [PAYLOAD_W-1:0]  rd_value_in,
  output logic                  start,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  is_read,
  output logic                  hold_en
);
  logic                 ext_q, ext_d;
  logic                 hold_q, hold_d;
  logic [FLD_W-1:0]     port_q, port_d;
  logic [FLD_W-1:0]     dev_q, dev_d;
  logic [PAYLOAD_W-1:0] adr_q, adr_d;
  logic [PAYLOAD_W-1:0] dat_q, dat_d;
  logic                 err_q, err_d;
  logic                 rdop_q, rdop_d;
  logic                 accept;

  assign accept = wr_en && !busy;

  always_comb begin
    ext_d   = ext_q;
    hold_d  = hold_q;
    port_d  = port_q;
    dev_d   = dev_q;
    adr_d   = adr_q;
    dat_d   = dat_q;
    err_d   = err_q;
    rdop_d  = rdop_q;
    start   = 1'b0;
    is_read = 1'b0;
    frame   = '0;
    if (accept) begin
      unique case (reg_sel_e'(addr))
        SEL_STATUS: begin
          ext_d  = wdata[0];
          hold_d = wdata[1];
        end
        SEL_CTRL: begin
          port_d = wdata[9:5];
          dev_d  = wdata[4:0];
          if (wdata[15]) begin
            start   = 1'b1;
            is_read = 1'b1;
            frame   = build_frame(ext_q, ext_q ? OP_C45_RD : OP_C22_RD,
                                  wdata[9:5], wdata[4:0], {PAYLOAD_W{1'b1}});
          end
        end
        SEL_ADDR: begin
          adr_d = wdata;
          if (ext_q) begin
            start = 1'b1;
            frame = build_frame(1'b1, OP_C45_ADR, port_q, dev_q, wdata);
          end
        end
        SEL_DATA: begin
          dat_d = wdata;
          start = 1'b1;
          frame = build_frame(ext_q, OP_WRITE, port_q, dev_q, wdata);
        end
        default: ;
      endcase
    end
    if (start) begin
      err_d  = 1'b0;
      rdop_d = is_read;
    end
    if (done && rdop_q) begin
      err_d = rd_err_in;
      dat_d = rd_err_in ? {PAYLOAD_W{1'b1}} : rd_value_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      hold_q <= 1'b0;
      port_q <= '0;
      dev_q  <= '0;
      adr_q  <= '0;
      dat_q  <= '0;
      err_q  <= 1'b0;
      rdop_q <= 1'b0;
    end else begin
      ext_q  <= ext_d;
      hold_q <= hold_d;
      port_q <= port_d;
      dev_q  <= dev_d;
      adr_q  <= adr_d;
      dat_q  <= dat_d;
      err_q  <= err_d;
      rdop_q <= rdop_d;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(addr))
      SEL_STATUS: rdata = {28'd0, err_q, busy, hold_q, ext_q};
      SEL_CTRL:   rdata = {22'd0, port_q, dev_q};
      SEL_ADDR:   rdata = {16'd0, adr_q};
      SEL_DATA:   rdata = {busy, 15'd0, dat_q};
      default:    rdata = '0;
    endcase
  end

  assign hold_en = hold_q;

  // R7: a flagged read always leaves all ones in the data register
  a_r7_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (dat_q == {PAYLOAD_W{1'b1}}));

  // R9: configuration untouched by writes issued while busy
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable({ext_q, hold_q, port_q, dev_q, adr_q}));

  // R9: no launch request while the engine runs
  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_DIV   = 40,
  parameter int HOLD_CLKS = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]            rst_pipe_q;
  logic                  rst_core_n;
  logic                  start, is_read, hold_en;
  logic [FRAME_BITS-1:0] frame;
  logic                  busy, done, rd_err;
  logic [PAYLOAD_W-1:0]  rd_value;
  logic                  launch, sample, bit_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  mdio_mgmt_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en       (reg_wr_en),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .busy        (busy),
    .done        (done),
    .rd_err_in   (rd_err),
    .rd_value_in (rd_value),
    .start       (start),
    .frame       (frame),
    .is_read     (is_read),
    .hold_en     (hold_en)
  );

  mdio_bit_timer #(.MDC_DIV(MDC_DIV), .HOLD_CLKS(HOLD_CLKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (busy),
    .hold_en (hold_en),
    .launch  (launch),
    .sample  (sample),
    .bit_end (bit_end),
    .mdc     (mdc)
  );

  mdio_frame_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .frame_in   (frame),
    .is_read_in (is_read),
    .launch     (launch),
    .sample     (sample),
    .bit_end    (bit_end),
    .mdio_i     (mdio_i),
    .busy       (busy),
    .done       (done),
    .rd_err     (rd_err),
    .rd_value   (rd_value),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
  localparam int DIV  = 8;
  localparam int HOLD = 3;
  localparam int FRAME_CYC = 64 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_chk = 0;
  int n_err = 0;

  // PHY model state
  int          phy_cnt = 0;
  int          oe_cnt = 0;
  int          tail_oe = 0;
  logic [63:0] phy_bits = '0;
  logic        respond = 1'b0;
  logic [15:0] resp = '0;
  logic        phy_drv = 1'b0;
  logic        phy_val = 1'b1;

  // timing monitor state
  logic mdc_prev = 1'b0, o_prev = 1'b1, oe_prev = 1'b0;
  int   gap = 1000, gap_min = 1000, gap_max = -1;
  int   hi_len = 0, lo_len = 0, last_hi = 0, last_lo = 0;

  always #2.5 clk = ~clk;

  assign mdio_i = phy_drv ? phy_val : 1'b1;

  mdio_mgmt_ctrl #(.MDC_DIV(DIV), .HOLD_CLKS(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    if (phy_cnt < 64) begin
      phy_bits[63 - phy_cnt] = mdio_o;
      if (mdio_oe) oe_cnt++;
      if (mdio_oe && phy_cnt >= 46) tail_oe++;
    end
    phy_cnt++;
  end

  always @(negedge mdc) begin
    if (respond) begin
      if (phy_cnt == 47) begin
        phy_drv = 1'b1;
        phy_val = 1'b0;
      end else if (phy_cnt >= 48 && phy_cnt <= 63) begin
        phy_val = resp[63 - phy_cnt];
      end
    end
  end

  always @(negedge clk) begin
    if (mdc_prev && !mdc) begin
      gap = 0; last_hi = hi_len; hi_len = 0;
    end else begin
      gap++;
    end
    if (!mdc_prev && mdc) begin
      last_lo = lo_len; lo_len = 0;
    end
    if (mdc) hi_len++; else lo_len++;
    if (mdio_oe && oe_prev && (mdio_o != o_prev)) begin
      if (gap < gap_min) gap_min = gap;
      if (gap > gap_max) gap_max = gap;
    end
    o_prev = mdio_o; oe_prev = mdio_oe; mdc_prev = mdc;
  end

  function automatic logic [63:0] exp_frame(input logic ext, input logic [1:0] op,
                                            input logic [4:0] prt, input logic [4:0] dev,
                                            input logic [15:0] pay);
    return {32'hFFFF_FFFF, (ext ? 2'b00 : 2'b01), op, prt, dev, 2'b10, pay};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    addr = 2'd0;
    #1;
    while (rdata[2] && cyc < 20000) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic phy_clear();
    phy_cnt = 0; oe_cnt = 0; tail_oe = 0; phy_bits = '0;
    phy_drv = 1'b0; phy_val = 1'b1;
    gap_min = 1000; gap_max = -1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk(v == 32'd0, "R1 register zero after reset", 64'(v), 64'd0);
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe low after reset",
        64'({mdc, mdio_oe}), 64'd0);
  endtask

  task automatic t_c22_write();
    int cyc;
    logic [63:0] e;
    wr(2'd0, 16'h0000);
    wr(2'd1, {6'd0, 5'h13, 5'h0A});
    phy_clear();
    wr(2'd3, 16'hA5C3);
    wait_idle(cyc);
    chk(cyc == FRAME_CYC, "R5 busy length", 64'(cyc), 64'(FRAME_CYC));
    e = exp_frame(1'b0, 2'b01, 5'h13, 5'h0A, 16'hA5C3);
    chk(phy_cnt == 64 && phy_bits == e, "R2 short write frame", phy_bits, e);
    chk(oe_cnt == 64, "R2 driven for whole write frame", 64'(oe_cnt), 64'd64);
    chk(gap_min == 0 && gap_max == 0, "R8 no hold: change with mdc fall",
        64'(gap_max), 64'd0);
    chk(last_hi == DIV/2 && last_lo == DIV/2, "R10 mdc half periods",
        64'({last_hi[31:0], last_lo[31:0]}), 64'({32'(DIV/2), 32'(DIV/2)}));
    repeat (20) @(negedge clk);
    chk(mdc == 1'b0 && phy_cnt == 64, "R10 mdc idle after frame", 64'(phy_cnt), 64'd64);
  endtask

  task automatic t_c45_addr();
    int cyc;
    logic [63:0] e;
    wr(2'd0, 16'h0003);
    wr(2'd1, {6'd0, 5'h01, 5'h1E});
    phy_clear();
    wr(2'd2, 16'h8001);
    wait_idle(cyc);
    e = exp_frame(1'b1, 2'b00, 5'h01, 5'h1E, 16'h8001);
    chk(phy_cnt == 64 && phy_bits == e, "R3 extended address frame", phy_bits, e);
    chk(gap_min == HOLD && gap_max == HOLD, "R8 hold stretch",
        64'(gap_min), 64'(HOLD));
  endtask

  task automatic t_c45_write_read();
    int cyc;
    logic [63:0] e;
    logic [31:0] v;
    phy_clear();
    wr(2'd3, 16'h1234);
    wait_idle(cyc);
    e = exp_frame(1'b1, 2'b01, 5'h01, 5'h1E, 16'h1234);
    chk(phy_bits == e, "R4 extended write frame", phy_bits, e);
    phy_clear();
    respond = 1'b1; resp = 16'hBEEF;
    wr(2'd1, {1'b1, 5'd0, 5'h01, 5'h1E});
    wait_idle(cyc);
    respond = 1'b0; phy_drv = 1'b0;
    e = exp_frame(1'b1, 2'b11, 5'h01, 5'h1E, 16'h0);
    chk(phy_bits[63:18] == e[63:18], "R4 extended read header",
        64'(phy_bits[63:18]), 64'(e[63:18]));
    chk(oe_cnt == 46 && tail_oe == 0, "R6 line released in read tail",
        64'(oe_cnt), 64'd46);
    rd(2'd3, v);
    chk(v[15:0] == 16'hBEEF, "R6 read data captured", 64'(v[15:0]), 64'hBEEF);
    rd(2'd0, v);
    chk(v[3] == 1'b0, "R7 no error on answered read", 64'(v[3]), 64'd0);
  endtask

  task automatic t_c22_addr_noframe();
    logic [31:0] v;
    wr(2'd0, 16'h0000);
    phy_clear();
    wr(2'd2, 16'h0077);
    repeat (40) @(negedge clk);
    rd(2'd0, v);
    chk(v[2] == 1'b0 && phy_cnt == 0, "R3 no frame in short mode",
        64'(phy_cnt), 64'd0);
    rd(2'd2, v);
    chk(v == 32'h77, "R3 address stored", 64'(v), 64'h77);
  endtask

  task automatic t_c22_read_err();
    int cyc;
    logic [31:0] v;
    logic [63:0] e;
    phy_clear();
    respond = 1'b0;
    wr(2'd1, {1'b1, 5'd0, 5'h02, 5'h03});
    wait_idle(cyc);
    e = exp_frame(1'b0, 2'b10, 5'h02, 5'h03, 16'h0);
    chk(phy_bits[63:18] == e[63:18], "R2 short read header",
        64'(phy_bits[63:18]), 64'(e[63:18]));
    rd(2'd0, v);
    chk(v[3] == 1'b1, "R7 error flag set", 64'(v[3]), 64'd1);
    rd(2'd3, v);
    chk(v[15:0] == 16'hFFFF, "R7 all ones on error", 64'(v[15:0]), 64'hFFFF);
    phy_clear();
    respond = 1'b1; resp = 16'h0F0F;
    wr(2'd1, {1'b1, 5'd0, 5'h02, 5'h03});
    wait_idle(cyc);
    respond = 1'b0; phy_drv = 1'b0;
    rd(2'd0, v);
    chk(v[3] == 1'b0, "R7 error cleared by new read", 64'(v[3]), 64'd0);
    rd(2'd3, v);
    chk(v[15:0] == 16'h0F0F, "R6 short read data", 64'(v[15:0]), 64'h0F0F);
  endtask

  task automatic t_busy_ignore();
    int cyc;
    logic [31:0] v;
    phy_clear();
    wr(2'd3, 16'h5555);
    rd(2'd3, v);
    chk(v[31] == 1'b1, "R5 data busy bit", 64'(v[31]), 64'd1);
    wr(2'd3, 16'hAAAA);
    wr(2'd2, 16'h1111);
    wr(2'd0, 16'h0001);
    wr(2'd1, {1'b1, 5'd0, 5'h1F, 5'h1F});
    wait_idle(cyc);
    repeat (40) @(negedge clk);
    rd(2'd0, v);
    chk(v[2] == 1'b0 && phy_cnt == 64, "R9 only one frame", 64'(phy_cnt), 64'd64);
    chk(v[0] == 1'b0, "R9 status write ignored", 64'(v[0]), 64'd0);
    rd(2'd3, v);
    chk(v[15:0] == 16'h5555, "R9 data write ignored", 64'(v[15:0]), 64'h5555);
    rd(2'd2, v);
    chk(v[15:0] == 16'h0077, "R9 address write ignored", 64'(v[15:0]), 64'h77);
    rd(2'd1, v);
    chk(v[9:0] == {5'h02, 5'h03}, "R9 control write ignored",
        64'(v[9:0]), 64'({5'h02, 5'h03}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_c22_write();
    t_c45_addr();
    t_c45_write_read();
    t_c22_addr_noframe();
    t_c22_read_err();
    t_busy_ignore();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule